// File: doc/BRIEF.md
# Cache Line Lock Tracker

This block keeps one lock flag for every line of a set-associative tag store. Software turns a lock window on and off through a small register port. Every allocation made while the window is open leaves its line locked. Every allocation made while the window is closed leaves its line unlocked. The replacement logic reads the flags of one set at a time. It must not pick a locked way as its victim. When every way of a set is locked, it gets a flag telling it to treat the access as non-allocating. The block also builds the tag word written for a new line, with the lock flag placed at bit 21.

Software can clear every lock at once by writing an unlock command. This starts a background sweep run by a two-state machine:
- `SW_IDLE` moves to `SW_RUN` on an accepted unlock command (transition *start*).
- `SW_RUN` clears one set per clock, starting at set 0.
- `SW_RUN` steps through the sets (transition *advance*) and returns to `SW_IDLE` after clearing the last set (transition *finish*).

While the sweep runs, a busy bit reads as 1. Nothing stops a sweep once it has started. A second unlock command arriving during a sweep is dropped.

Top module: `line_lock_tracker`

## Requirements
- R1: The lock-enable register sits at register address 0, in bit 0 of the write and read data. It resets to 0. Writing to address 0 loads bit 0, and reading address 0 returns it in bit 0 with all other bits 0.
- R2: An allocation (`alloc_valid`) while lock-enable is 1 sets the flag of the way `alloc_way` in set `alloc_set`. The new flag is visible on the query port from the cycle after the allocation edge.
- R3: An allocation while lock-enable is 0 clears the flag of that way. The other ways of the set keep their flags.
- R4: `query_locked` gives the flags of set `query_set` combinationally, with bit i standing for way i. After reset every flag is 0.
- R5: `query_no_victim` is 1 exactly when every way of `query_set` is locked.
- R6: `tag_word_o` equals `alloc_tag_i` except at bit 21, which carries the current lock-enable value.
- R7: Writing 1 in bit 0 to register address 1 while idle starts a sweep. Reading address 1 returns the busy flag in bit 0. The busy flag is 1 for exactly NUM_SETS cycles, starting the cycle after the write. Set i is cleared at the edge ending the i-th busy cycle.
- R8: Once a sweep has finished, every flag set before the sweep started reads 0.
- R9: An unlock write that arrives while a sweep is running is ignored. The sweep neither restarts nor ends later than it would have.
- R10: An allocation during a sweep uses the current lock-enable value. Its flag is cleared later if the sweep has not yet reached that set. It survives if the set was already swept, or if the sweep clears that set on the same edge.
- R11: Writing 0 in bit 0 to address 1 starts nothing and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 lock-enable, 1 unlock/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| alloc_valid | input | 1 | A line is being allocated this cycle |
| alloc_set | input | SET_W | Set index of the allocation |
| alloc_way | input | WAY_W | Way of the allocation |
| alloc_tag_i | input | TAG_W | Tag word of the new line |
| tag_word_o | output | TAG_W | Tag word with the lock flag at bit 21 |
| query_set | input | SET_W | Set looked up by the replacement logic |
| query_locked | output | NUM_WAYS | Lock flags of `query_set` |
| query_no_victim | output | 1 | All ways of `query_set` are locked |

## Verification
The bench goes after the sweep's timing. Each step checks busy against a cycle-exact model, so a sweep that is one cycle too short or too long, or starts at the wrong set, leaves flags out of step with the model. Unlock writes are repeated in the middle of a sweep; a design that restarted would stay busy too long. Allocations are aimed at sets ahead of, behind, and on the sweep pointer; a design that let the clear win on the shared edge would lose a fresh lock. Sets are filled to check the no-victim flag, and unlocked allocations are made over locked ways to catch designs that only ever set flags.

// File: rtl/line_lock_pkg.sv
package line_lock_pkg;

    typedef enum logic [0:0] {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_t;

    localparam int unsigned LOCK_TAG_BIT = 21;

    localparam logic REG_ENABLE = 1'b0;
    localparam logic REG_UNLOCK = 1'b1;

endpackage

// File: rtl/lk_regs.sv
module lk_regs
    import line_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        sweep_busy,
    output logic        lock_en,
    output logic        unlock_req,
    output logic [31:0] reg_rdata
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_en <= 1'b0;
        end else if (reg_wr && reg_addr == REG_ENABLE) begin
            lock_en <= reg_wdata[0];
        end
    end

    always_comb begin
        unlock_req = reg_wr && (reg_addr == REG_UNLOCK) && reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_ENABLE: reg_rdata[0] = lock_en;
            REG_UNLOCK: reg_rdata[0] = sweep_busy;
            default:    reg_rdata = '0;
        endcase
    end

    // R1: a write to the enable register shows up on the next cycle
    p_enable_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_ENABLE) |=> (lock_en == $past(reg_wdata[0])));

endmodule

// File: rtl/lk_sweep_fsm.sv
module lk_sweep_fsm
    import line_lock_pkg::*;
#(
    parameter int unsigned NUM_SETS = 16,
    localparam int unsigned SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unlock_req,
    output logic             busy,
    output logic             clr_valid,
    output logic [SET_W-1:0] clr_set
);

    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

    sweep_state_t     state_q, state_d;
    logic [SET_W-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions: start, advance, finish
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SW_IDLE: begin
                if (unlock_req) begin
                    state_d = SW_RUN;
                    idx_d   = '0;
                end
            end
            SW_RUN: begin
                if (idx_q == LAST_SET) begin
                    state_d = SW_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        clr_valid = 1'b0;
        clr_set   = idx_q;
        unique case (state_q)
            SW_IDLE: begin
                busy      = 1'b0;
                clr_valid = 1'b0;
            end
            SW_RUN: begin
                busy      = 1'b1;
                clr_valid = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // R7: every sweep begins at set 0
    p_start_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (clr_set == '0));

    // R7: the sweep stops right after clearing the last set
    p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && clr_set == LAST_SET) |=> !busy);

    // R9: an unlock request during a sweep does not restart it
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && unlock_req && clr_set != LAST_SET) |=>
            (busy && clr_set == $past(clr_set) + 1'b1));

endmodule

// File: rtl/lk_flag_array.sv
module lk_flag_array #(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_valid,
    input  logic [SET_W-1:0]    clr_set,
    input  logic                alloc_valid,
    input  logic [SET_W-1:0]    alloc_set,
    input  logic [WAY_W-1:0]    alloc_way,
    input  logic                alloc_lock,
    input  logic [SET_W-1:0]    query_set,
    output logic [NUM_WAYS-1:0] query_locked,
    output logic                query_all_locked
);

    logic [NUM_WAYS-1:0] flags_q [NUM_SETS];
    logic [NUM_SETS-1:0] set_full;

    // sweep clear first, then allocation, so a same-edge allocation survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                flags_q[s] <= '0;
            end
        end else begin
            if (clr_valid) begin
                flags_q[clr_set] <= '0;
            end
            if (alloc_valid) begin
                flags_q[alloc_set][alloc_way] <= alloc_lock;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_SETS; g++) begin : g_full
            assign set_full[g] = &flags_q[g];
        end
    endgenerate

    always_comb begin
        query_locked     = flags_q[query_set];
        query_all_locked = set_full[query_set];
    end

    // checker copies of the previous cycle's writes
    logic                chk_alloc_v;
    logic [SET_W-1:0]    chk_alloc_set;
    logic [WAY_W-1:0]    chk_alloc_way;
    logic                chk_alloc_lock;
    logic                chk_clr_v;
    logic [SET_W-1:0]    chk_clr_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_alloc_v    <= 1'b0;
            chk_alloc_set  <= '0;
            chk_alloc_way  <= '0;
            chk_alloc_lock <= 1'b0;
            chk_clr_v      <= 1'b0;
            chk_clr_set    <= '0;
        end else begin
            chk_alloc_v    <= alloc_valid;
            chk_alloc_set  <= alloc_set;
            chk_alloc_way  <= alloc_way;
            chk_alloc_lock <= alloc_lock;
            chk_clr_v      <= clr_valid && !(alloc_valid && alloc_set == clr_set);
            chk_clr_set    <= clr_set;
        end
    end

    // R2: an allocated way holds the lock value it was written with
    p_alloc_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_alloc_v |-> (flags_q[chk_alloc_set][chk_alloc_way] == chk_alloc_lock));

    // R7: a swept set with no competing allocation is empty afterwards
    p_sweep_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_clr_v |-> (flags_q[chk_clr_set] == '0));

endmodule

// File: rtl/line_lock_tracker.sv
module line_lock_tracker
    import line_lock_pkg::*;
#(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned TAG_W    = 32,
    localparam int unsigned SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                alloc_valid,
    input  logic [SET_W-1:0]    alloc_set,
    input  logic [WAY_W-1:0]    alloc_way,
    input  logic [TAG_W-1:0]    alloc_tag_i,
    output logic [TAG_W-1:0]    tag_word_o,
    input  logic [SET_W-1:0]    query_set,
    output logic [NUM_WAYS-1:0] query_locked,
    output logic                query_no_victim
);

    localparam logic [TAG_W-1:0] LOCK_MASK = TAG_W'(1) << LOCK_TAG_BIT;

    logic             lock_en;
    logic             unlock_req;
    logic             sweep_busy;
    logic             clr_valid;
    logic [SET_W-1:0] clr_set;

    lk_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .sweep_busy (sweep_busy),
        .lock_en    (lock_en),
        .unlock_req (unlock_req),
        .reg_rdata  (reg_rdata)
    );

    lk_sweep_fsm #(
        .NUM_SETS (NUM_SETS)
    ) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock_req (unlock_req),
        .busy       (sweep_busy),
        .clr_valid  (clr_valid),
        .clr_set    (clr_set)
    );

    lk_flag_array #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS)
    ) u_flags (
        .clk              (clk),
        .rst_n            (rst_n),
        .clr_valid        (clr_valid),
        .clr_set          (clr_set),
        .alloc_valid      (alloc_valid),
        .alloc_set        (alloc_set),
        .alloc_way        (alloc_way),
        .alloc_lock       (lock_en),
        .query_set        (query_set),
        .query_locked     (query_locked),
        .query_all_locked (query_no_victim)
    );

    always_comb begin
        tag_word_o = (alloc_tag_i & ~LOCK_MASK) | (lock_en ? LOCK_MASK : '0);
    end

    // R6: only the lock bit of the tag word may differ from the input tag
    p_tag_other_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones((tag_word_o ^ alloc_tag_i) & ~LOCK_MASK) == 0);

    // R5: no-victim is raised only over a fully locked set
    p_no_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        query_no_victim |-> ($countones(query_locked) == NUM_WAYS));

endmodule

// File: tb/line_lock_tracker_test.sv
module line_lock_tracker_test;

    localparam int CLK_PERIOD = 10;
    localparam int S  = 16;
    localparam int W  = 4;
    localparam int SW = 4;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          alloc_valid = 1'b0;
    logic [SW-1:0] alloc_set = '0;
    logic [WW-1:0] alloc_way = '0;
    logic [31:0]   alloc_tag_i = '0;
    logic [31:0]   tag_word_o;
    logic [SW-1:0] query_set = '0;
    logic [W-1:0]  query_locked;
    logic          query_no_victim;

    int total = 0;
    int bad = 0;

    logic [W-1:0]  m_flags [S];
    logic          m_en;
    logic          m_busy;
    int            m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_lock_tracker uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .alloc_valid     (alloc_valid),
        .alloc_set       (alloc_set),
        .alloc_way       (alloc_way),
        .alloc_tag_i     (alloc_tag_i),
        .tag_word_o      (tag_word_o),
        .query_set       (query_set),
        .query_locked    (query_locked),
        .query_no_victim (query_no_victim)
    );

    function automatic logic [31:0] exp_tag(input logic [31:0] t, input logic en);
        logic [31:0] r;
        r = t;
        r[21] = en;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < S; s++) m_flags[s] = '0;
        m_en = 1'b0;
        m_busy = 1'b0;
        m_idx = 0;
    endtask

    // one clock: drive at negedge, update model at the edge, inputs released
    task automatic step(input bit wr, input bit addr, input logic [31:0] wd,
                        input bit av, input int aset, input int away, input logic [31:0] tag);
        reg_wr      = wr;
        reg_addr    = addr;
        reg_wdata   = wd;
        alloc_valid = av;
        alloc_set   = SW'(aset);
        alloc_way   = WW'(away);
        alloc_tag_i = tag;
        #1;
        chk(tag_word_o == exp_tag(tag, m_en), "R6 tag word", tag_word_o, exp_tag(tag, m_en));
        @(posedge clk);
        // sweep clear precedes the allocation (R10)
        if (m_busy) begin
            m_flags[m_idx] = '0;
            if (m_idx == S-1) begin
                m_busy = 1'b0;
                m_idx = 0;
            end else begin
                m_idx++;
            end
        end else if (wr && addr == 1'b1 && wd[0]) begin
            m_busy = 1'b1;
            m_idx = 0;
        end
        if (av) m_flags[aset][away] = m_en;
        if (wr && addr == 1'b0) m_en = wd[0];
        @(negedge clk);
        reg_wr = 1'b0;
        alloc_valid = 1'b0;
    endtask

    task automatic check_set(input int q, input string req);
        query_set = SW'(q);
        #1;
        chk(query_locked == m_flags[q], req, 32'(query_locked), 32'(m_flags[q]));
        chk(query_no_victim == (&m_flags[q]), "R5 no-victim", 32'(query_no_victim), 32'(&m_flags[q]));
    endtask

    task automatic check_regs();
        reg_addr = 1'b0;
        #1;
        chk(reg_rdata == {31'b0, m_en}, "R1 enable readback", reg_rdata, {31'b0, m_en});
        reg_addr = 1'b1;
        #1;
        chk(reg_rdata == {31'b0, m_busy}, "R7 busy readback", reg_rdata, {31'b0, m_busy});
    endtask

    task automatic check_all(input string req);
        for (int s = 0; s < S; s++) check_set(s, req);
        check_regs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 0, 0, 0, 32'h0);
            check_regs();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R1: reset state
        check_all("R4 reset flags");

        // R1: enable on
        step(1, 0, 32'h1, 0, 0, 0, 32'h0);
        check_regs();

        // R2 + R5: fill set 3 with locks
        for (int w = 0; w < W; w++) begin
            step(0, 0, 0, 1, 3, w, 32'hFFFF_FFFF);
            check_set(3, "R2 locked alloc");
        end
        check_set(3, "R5 full set");

        // R3: enable off, unlocked alloc over a locked way
        step(1, 0, 32'h0, 0, 0, 0, 32'h0);
        step(0, 0, 0, 1, 3, 2, 32'h0020_0000);
        check_set(3, "R3 unlocked alloc");

        // lock some lines in various sets
        step(1, 0, 32'h1, 0, 0, 0, 32'h0);
        step(0, 0, 0, 1, 0, 0, 32'h0);
        step(0, 0, 0, 1, 15, 3, 32'h0);
        step(0, 0, 0, 1, 8, 1, 32'h0);
        check_all("R2 lock set");

        // R11: writing 0 to unlock starts nothing
        step(1, 1, 32'h0, 0, 0, 0, 32'h0);
        check_all("R11 zero unlock");

        // R7/R9/R10: sweep with repeated request and allocations around pointer
        step(1, 1, 32'h1, 0, 0, 0, 32'h0);
        check_regs();
        step(1, 1, 32'h1, 0, 0, 0, 32'h0);      // R9 ignored (sweep at set 0)
        check_regs();
        step(0, 0, 0, 1, 0, 1, 32'h0);          // R10 behind pointer, survives
        step(0, 0, 0, 1, 12, 2, 32'h0);         // R10 ahead, cleared later
        // pointer now at 3: allocate on same edge
        step(0, 0, 0, 1, 3, 0, 32'h0);          // R10 same edge, survives
        step(1, 1, 32'h1, 0, 0, 0, 32'h0);      // R9 again
        while (m_busy) begin
            step(0, 0, 0, 0, 0, 0, 32'h0);
            check_regs();
        end
        check_all("R8 after sweep / R10");
        idle(2);

        // R7: busy length exactly S cycles
        begin
            int cnt;
            cnt = 0;
            step(1, 1, 32'h1, 0, 0, 0, 32'h0);
            reg_addr = 1'b1;
            #1;
            while (reg_rdata[0] && cnt < S + 4) begin
                cnt++;
                step(0, 1, 0, 0, 0, 0, 32'h0);
                reg_addr = 1'b1;
                #1;
            end
            chk(cnt == S, "R7 sweep length", 32'(cnt), 32'(S));
        end
        check_all("R8 all clear");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit wr, ad;
            logic [31:0] wd;
            r = int'($urandom_range(0, 99));
            wr = 0; ad = 0; wd = 0;
            if (r < 8) begin wr = 1; ad = 0; wd = {31'b0, 1'($urandom_range(0, 1))}; end
            else if (r < 10) begin wr = 1; ad = 1; wd = $urandom; end
            step(wr, ad, wd, ($urandom_range(0, 99) < 60), int'($urandom_range(0, S-1)),
                 int'($urandom_range(0, W-1)), $urandom);
            check_set(int'($urandom_range(0, S-1)), "R4 random query");
            check_regs();
        end
        check_all("R4 final scan");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule